// File: doc/BRIEF.md
# Synchronous-Terminated Memory Slave

This block is the memory side of a 32-bit processor bus that uses an address strobe. It watches the strobes, the read/write line, the function code and the long-word address. A cycle that hits its window is answered with read data, or a write is taken, after a configurable number of wait clocks. Every transfer is then closed with a termination strobe that lasts one clock and is driven only from the rising clock edge, so the master samples it without a synchronizer. Only full 32-bit long-word transfers exist. With zero wait clocks an access takes two clocks.

When the master raises the burst request at the start of a cycle, the block answers with a burst acknowledge and fills, or takes, a 16-byte cache line. The line is four long words, and the beat address wraps within the aligned line. Each further beat can end one clock after the previous one, and a separate parameter inserts wait clocks between beats. A small internal word array stands in for real memory, so the block can be exercised on its own.

Top module: `sterm_mem_slave`

## Requirements
- R1: After reset, term_o, burst_ack_o and rdata_oe_o are low and rdata_o is zero. Array word i holds i*32'h9E3779B9 (mod 2^32).
- R2: For a cycle that hits, the first term_o is high in clock WAIT_FIRST+1, counting the clock after the first rising edge that samples addr_strobe_i high as clock 1. term_o is never high in the first clock of a strobe, so an access takes at least two clocks.
- R3: term_o is high for exactly one clock per transfer. It is low whenever addr_strobe_i is low. After the final transfer no further term_o appears until the strobe drops.
- R4: A read presents, in the term_o clock, the word at array index addr_i[2 +: IDX_W]. A write with data_strobe_i high stores wdata_i at the rising edge that ends the term_o clock.
- R5: If burst_req_i is high when the cycle starts, burst_ack_o rises together with the first term_o and stays high through the last beat. Each later beat's term_o comes WAIT_BEAT+1 clocks after the previous one. Without a request, burst_ack_o stays low.
- R6: Beat k of a burst uses index {start[IDX_W-1:2], start[1:0]+k mod 4}, so the address wraps inside the aligned 4-word line.
- R7: A burst ends after the fourth beat, or at the first term_o edge that samples burst_req_i low.
- R8: rdata_oe_o is high only in the clock after an edge that sampled addr_strobe_i and read_i high on a hit. It goes low in the clock after the strobe is negated. rdata_o is zero whenever rdata_oe_o is low.
- R9: A cycle with fc_i = 3'b111 (processor space), or with addr_i above the IDX_W index bits not equal to BASE_ADDR, is ignored. No term_o, no data drive and no array write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_strobe_i | input | 1 | Address strobe, high while a cycle is in progress |
| data_strobe_i | input | 1 | Data strobe, qualifies write data |
| read_i | input | 1 | 1 = read, 0 = write |
| fc_i | input | 3 | Function code; 3'b111 is processor space |
| addr_i | input | ADDR_W-2 | Long-word address (byte address bits ADDR_W-1..2) |
| wdata_i | input | 32 | Write data |
| burst_req_i | input | 1 | Burst request from the master |
| burst_ack_o | output | 1 | Burst granted, high across the line's beats |
| term_o | output | 1 | Synchronous termination strobe, one clock per transfer |
| rdata_o | output | 32 | Read data, zero when not driven |
| rdata_oe_o | output | 1 | Read data drive enable |

## Verification
The hardest situation to reach is a burst that starts mid-line, wraps past the line end and is cut short by the master. Here the wrapped index, the burst-acknowledge span and the stop in the right clock must all line up. The bench drives directed bursts from word 3 of a line and drops burst_req_i in the final term clock after two beats. Randomly placed bursts of one to four beats, mixed reads and writes, then cover the other start positions and lengths. The results are compared against a shadow copy of the array.

// File: rtl/sts_pkg.sv
package sts_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_TERM,
    ST_DONE
  } sts_state_e;

  localparam logic [2:0] FC_CPU_SPACE = 3'b111;
endpackage

// File: rtl/sts_wait_timer.sv
module sts_wait_timer #(
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sts_beat_addr.sv
module sts_beat_addr #(
  parameter int IDX_W  = 6,
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  start_idx_i,
  input  logic              adv_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              last_o
);
  logic [IDX_W-1:0]  base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] word_sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (start_i) begin
      base_q <= start_idx_i;
      beat_q <= '0;
    end else if (adv_i) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  // wrap inside the aligned line
  assign word_sum = base_q[BEAT_W-1:0] + beat_q;
  assign idx_o    = {base_q[IDX_W-1:BEAT_W], word_sum};
  assign beat_o   = beat_q;
  assign last_o   = (beat_q == {BEAT_W{1'b1}});
endmodule

// File: rtl/sts_mem.sv
module sts_mem #(
  parameter int          DEPTH     = 64,
  parameter int          DW        = 32,
  parameter logic [31:0] INIT_MULT = 32'h9E37_79B9,
  localparam int         IDX_W     = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= DW'(i) * DW'(INIT_MULT);
    end else if (we_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/sterm_mem_slave.sv
module sterm_mem_slave
  import sts_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          DEPTH      = 64,
  parameter int          LINE_BEATS = 4,
  parameter int          WAIT_FIRST = 1,
  parameter int          WAIT_BEAT  = 0,
  parameter logic [31:0] BASE_ADDR  = 32'h0,
  localparam int         DW         = 32,
  localparam int         IDX_W      = $clog2(DEPTH),
  localparam int         BEAT_W     = $clog2(LINE_BEATS),
  localparam int         CW         = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_strobe_i,
  input  logic              data_strobe_i,
  input  logic              read_i,
  input  logic [2:0]        fc_i,
  input  logic [ADDR_W-1:2] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              burst_req_i,
  output logic              burst_ack_o,
  output logic              term_o,
  output logic [DW-1:0]     rdata_o,
  output logic              rdata_oe_o
);
  sts_state_e       state_q, state_d;
  logic             hit;
  logic             start;
  logic             burst_q;
  logic             oe_q;
  logic             tmr_load;
  logic [CW-1:0]    tmr_val;
  logic             tmr_zero;
  logic             beat_adv;
  logic [IDX_W-1:0] idx;
  logic [BEAT_W-1:0] beat;
  logic             last_beat;
  logic             mem_we;
  logic [DW-1:0]    mem_rdata;

  assign hit = (fc_i != FC_CPU_SPACE) &&
               (addr_i[ADDR_W-1:IDX_W+2] == BASE_ADDR[ADDR_W-1:IDX_W+2]);
  assign start = (state_q == ST_IDLE) && addr_strobe_i && hit;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    beat_adv = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (addr_strobe_i) begin
          if (!hit) begin
            state_d = ST_DONE;
          end else if (WAIT_FIRST == 0) begin
            state_d = ST_TERM;
          end else begin
            state_d  = ST_WAIT;
            tmr_load = 1'b1;
            tmr_val  = CW'(WAIT_FIRST - 1);
          end
        end
      end
      ST_WAIT: begin
        if (!addr_strobe_i) state_d = ST_IDLE;
        else if (tmr_zero)  state_d = ST_TERM;
      end
      ST_TERM: begin
        if (!addr_strobe_i) begin
          state_d = ST_IDLE;
        end else if (burst_q && !last_beat && burst_req_i) begin
          beat_adv = 1'b1;
          if (WAIT_BEAT != 0) begin
            state_d  = ST_WAIT;
            tmr_load = 1'b1;
            tmr_val  = CW'(WAIT_BEAT - 1);
          end
        end else begin
          state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        if (!addr_strobe_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      burst_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start) burst_q <= burst_req_i;
      oe_q <= addr_strobe_i && read_i && hit;
    end
  end

  sts_wait_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  sts_beat_addr #(.IDX_W(IDX_W), .BEAT_W(BEAT_W)) u_beat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .start_idx_i (addr_i[IDX_W+1:2]),
    .adv_i       (beat_adv),
    .idx_o       (idx),
    .beat_o      (beat),
    .last_o      (last_beat)
  );

  assign mem_we = (state_q == ST_TERM) && addr_strobe_i && !read_i && data_strobe_i;

  sts_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .idx_i   (idx),
    .wdata_i (wdata_i),
    .rdata_o (mem_rdata)
  );

  assign term_o      = (state_q == ST_TERM) && addr_strobe_i;
  assign burst_ack_o = burst_q && addr_strobe_i &&
                       ((state_q == ST_TERM) || ((state_q == ST_WAIT) && (beat != '0)));
  assign rdata_oe_o  = oe_q;
  assign rdata_o     = oe_q ? mem_rdata : '0;
endmodule

// File: rtl/sterm_mem_slave_chk.sv
module sterm_mem_slave_chk #(
  parameter int LINE_BEATS = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic addr_strobe_i,
  input logic read_i,
  input logic term_o,
  input logic burst_ack_o,
  input logic rdata_oe_o
);
  logic [7:0] term_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             term_cnt_q <= '0;
    else if (!addr_strobe_i) term_cnt_q <= '0;
    else if (term_o)         term_cnt_q <= term_cnt_q + 1'b1;
  end

  a_r2_min_two_clocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o |-> $past(addr_strobe_i));

  a_r3_single_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_o && !burst_ack_o) |=> !term_o);

  a_r5_ack_with_term: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(burst_ack_o) |-> term_o);

  a_r7_beat_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o |-> (term_cnt_q < 8'(LINE_BEATS)));

  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_strobe_i |=> !rdata_oe_o);

  a_r8_oe_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_oe_o |-> $past(addr_strobe_i && read_i));
endmodule

bind sterm_mem_slave sterm_mem_slave_chk #(.LINE_BEATS(LINE_BEATS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_strobe_i (addr_strobe_i),
  .read_i        (read_i),
  .term_o        (term_o),
  .burst_ack_o   (burst_ack_o),
  .rdata_oe_o    (rdata_oe_o)
);

// File: tb/sterm_mem_slave_tb.sv
module sterm_mem_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int DEPTH      = 64;
  localparam int WAIT_FIRST = 1;
  localparam int WAIT_BEAT  = 0;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              addr_strobe_i = 1'b0;
  logic              data_strobe_i = 1'b0;
  logic              read_i = 1'b1;
  logic [2:0]        fc_i = 3'b101;
  logic [ADDR_W-1:2] addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic              burst_req_i = 1'b0;
  logic              burst_ack_o;
  logic              term_o;
  logic [31:0]       rdata_o;
  logic              rdata_oe_o;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_mem [DEPTH];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sterm_mem_slave #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .WAIT_FIRST(WAIT_FIRST), .WAIT_BEAT(WAIT_BEAT)
  ) u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int beat_idx(input logic [31:0] byte_addr, input int k);
    int s = int'((byte_addr >> 2) % DEPTH);
    return (s & ~3) | ((s + k) & 3);
  endfunction

  // one bus cycle; nb = beats wanted (burst) ; returns nothing, checks inline
  task automatic bus_cycle(input logic [31:0] byte_addr, input bit rd, input bit burst,
                           input int nb, input logic [2:0] fc);
    int k = 0, last_k = 0, beat = 0, exp_k, want, idx;
    bit done = 0;
    bit hit = (fc != 3'b111) && (byte_addr[31:8] == 24'h0);
    want = burst ? nb : 1;
    @(negedge clk_i);
    addr_i = byte_addr[31:2]; read_i = rd; fc_i = fc;
    addr_strobe_i = 1'b1; data_strobe_i = 1'b1; burst_req_i = burst;
    wdata_i = $urandom;
    @(posedge clk_i);
    while (!done) begin
      @(negedge clk_i);
      k++;
      if (!rd) wdata_i = $urandom;
      if (!hit) begin
        chk(!term_o, "R9 no term", 32'(term_o), 0);
        chk(!rdata_oe_o, "R9 no drive", 32'(rdata_oe_o), 0);
        if (k >= 6) done = 1;
      end else if (k > 40) begin
        chk(0, "R2 watchdog no term", 32'(k), 32'(exp_k));
        done = 1;
      end else if (term_o) begin
        exp_k = (beat == 0) ? WAIT_FIRST + 1 : last_k + WAIT_BEAT + 1;
        chk(k == exp_k, beat == 0 ? "R2 first latency" : "R5 beat spacing", 32'(k), 32'(exp_k));
        chk(burst_ack_o == burst, "R5 burst ack", 32'(burst_ack_o), 32'(burst));
        idx = beat_idx(byte_addr, beat);
        if (rd) begin
          chk(rdata_oe_o, "R8 oe in read", 32'(rdata_oe_o), 1);
          chk(rdata_o == exp_mem[idx], beat == 0 ? "R4 read data" : "R6 wrap data",
              rdata_o, exp_mem[idx]);
        end else begin
          exp_mem[idx] = wdata_i;
        end
        beat++; last_k = k;
        if (beat >= want) begin
          burst_req_i = 1'b0;
          done = 1;
        end
      end
    end
    @(negedge clk_i);
    chk(!term_o, "R7 no term after final", 32'(term_o), 0);
    if (hit) chk(beat == want, "R7 beat count", 32'(beat), 32'(want));
    addr_strobe_i = 1'b0; data_strobe_i = 1'b0; burst_req_i = 1'b0;
    chk(!term_o, "R3 no term without strobe", 32'(term_o), 0);
    @(negedge clk_i);
    chk(!rdata_oe_o && rdata_o == 0, "R8 release", rdata_o, 0);
    chk(!burst_ack_o, "R5 ack low idle", 32'(burst_ack_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed = $urandom(32'h5a17);
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 32'(i) * 32'h9E37_79B9;
    repeat (3) @(negedge clk_i);
    chk(!term_o && !burst_ack_o && !rdata_oe_o && rdata_o == 0, "R1 reset outputs",
        {29'b0, term_o, burst_ack_o, rdata_oe_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!term_o && !rdata_oe_o, "R1 after release", 32'(term_o), 0);
    bus_cycle(32'h14, 1, 0, 1, 3'b101);      // R1 init word, R4 single read
    bus_cycle(32'h0C, 1, 1, 4, 3'b110);      // R6 wrap 3,0,1,2
    bus_cycle(32'h2C, 1, 1, 2, 3'b101);      // R7 cut after two beats
    bus_cycle(32'h28, 0, 1, 4, 3'b101);      // burst write
    bus_cycle(32'h20, 1, 1, 4, 3'b101);      // read back
    bus_cycle(32'h40, 0, 0, 1, 3'b111);      // R9 processor space write ignored
    bus_cycle(32'h1040, 0, 0, 1, 3'b101);    // R9 outside window ignored
    bus_cycle(32'h40, 1, 0, 1, 3'b101);      // R9 word unchanged
    for (int n = 0; n < 60; n++) begin
      logic [31:0] a = {24'h0, 6'($urandom), 2'b00};
      bus_cycle(a, 1'($urandom), 1'($urandom), 1 + int'($urandom % 4), 3'b001);
    end
    for (int i = 0; i < DEPTH; i += 4) bus_cycle(32'(i * 4), 1, 1, 4, 3'b101);
    if (seed == 0) $display("seed zero");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule